// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Event Detection

This block is a memory-mapped general-purpose I/O port with 32 pins. Software drives each pin from an output latch and makes it an output or an input with a direction bit. The synchronised level of every pin can be read back at any time. Each pin can also be watched for an event. The event is a low level, a high level, a rising edge, a falling edge, or either edge. A detected event is recorded in a sticky status bit, and software clears that bit by writing a one to it.

The per-pin status bits are gated by a mask register and then folded into two interrupt lines. One line covers pins 0 to 15 and the other covers pins 16 to 31. This lets an interrupt handler narrow down the source with one read of the status register. The bus port is a simple single-cycle interface. Writes are taken on the clock edge while select and write are both high. Read data is combinational from the address whenever select is high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Synchronous active-low reset clears every register. While in reset and on the cycle it ends, `pin_out`, `pin_oe`, `irq_lo` and `irq_hi` are 0 and the status register reads 0.
- R2: Bit n of the output latch drives `pin_out[n]`, and bit n of the direction register drives `pin_oe[n]` (1 = output). Reading the output latch returns the written value, not the pin level. `pin_out` changes only on a write to the latch.
- R3: The input-level register returns `pin_in` after two clock edges. Before the second edge it still shows the old value. Writes to it have no effect.
- R4: Each pin has a 2-bit condition code: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. For pins n < 16 the code sits in the lower configuration register at bits [2n+1:2n]. For pins 16 to 31 it sits in the upper configuration register at bits [2(n-16)+1:2(n-16)].
- R5: A level condition sets the pin's status bit on every cycle the level holds, so the bit comes back at once after being cleared.
- R6: An edge condition sets the status bit on the third clock edge after the pin input changes. The opposite edge leaves the bit untouched.
- R7: When a pin's both-edges bit is 1, its condition code is ignored and the pin flags on rising and on falling edges.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If an event and a clearing write hit the same bit on the same edge, the bit ends up set.
- R9: `irq_lo` is the OR of status AND mask over pins 0 to 15, and `irq_hi` is the same over pins 16 to 31. With an all-zero mask, both lines stay low.
- R10: The register byte offsets are: output latch 0x00, direction 0x04, input level 0x08, lower configuration 0x0C, upper configuration 0x10, mask 0x14, status 0x18, both-edges 0x1C. Written registers read back their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when not selected) |
| pin_in | input | 32 | Pin levels, asynchronous |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Combined interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Combined interrupt for pins 16 to 31 |

## Verification
The bench samples status on the first, second and third edge after a pin change. A design that flags one cycle early or late fails the third-edge check, and one without a real synchroniser shows the new input level too soon. One test flips pin 17 up and pin 18 down on the same edge, each with a different condition code in the upper configuration register. A design that places the fields at the wrong offset, or reads them from the lower register, flags the wrong pins. Other tests clear a held level condition, give pin 0 the low-level code while its both-edges bit is set, and clear one status bit while another is pending. A design that lets the clear win, honours the code under the both-edges bit, or clears whole words would leave status or an interrupt line at the wrong value.

// File: rtl/gpio_pkg.sv
// Package: shared register offsets and the condition encoding of the pin controller.
// Assumes a byte-addressed bus with one 32-bit word per register.
package gpio_pkg;

    // Per-pin trigger condition as held in the configuration fields.
    typedef enum logic [1:0] {
        COND_LOW  = 2'd0,
        COND_HIGH = 2'd1,
        COND_RISE = 2'd2,
        COND_FALL = 2'd3
    } gpio_cond_e;

    // Register byte offsets.
    localparam logic [7:0] OFF_DOUT  = 8'h00;
    localparam logic [7:0] OFF_DIR   = 8'h04;
    localparam logic [7:0] OFF_LEVEL = 8'h08;
    localparam logic [7:0] OFF_CFGLO = 8'h0C;
    localparam logic [7:0] OFF_CFGHI = 8'h10;
    localparam logic [7:0] OFF_MASK  = 8'h14;
    localparam logic [7:0] OFF_STAT  = 8'h18;
    localparam logic [7:0] OFF_BOTH  = 8'h1C;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchroniser for the pin inputs plus a one-cycle history stage.
// Assumes pin inputs are asynchronous and each bit is independent (no bus coherency).
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);

    logic [W-1:0] meta;

    // Shift the raw pins through two sync flops, then keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta     <= '0;
            lvl      <= '0;
            lvl_prev <= '0;
        end else begin
            meta     <= raw;
            lvl      <= meta;
            lvl_prev <= lvl;
        end
    end

endmodule

// File: rtl/gpio_cond_detect.sv
// Module: per-pin event detector, combinational.
// Picks each pin's 2-bit condition from the lower or upper configuration word
// and raises a hit when that condition holds this cycle. A both-edges bit
// overrides the code. Assumes NPINS is even and both words are NPINS bits wide.
module gpio_cond_detect
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] lvl_prev,
    input  logic [NPINS-1:0] cfg_lo,
    input  logic [NPINS-1:0] cfg_hi,
    input  logic [NPINS-1:0] both_edge,
    output logic [NPINS-1:0] hit
);

    localparam int HALF = NPINS / 2;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [1:0] code;
        logic       rise;
        logic       fall;
        logic       hit_b;

        if (i < HALF) begin : g_lo
            assign code = cfg_lo[2*i +: 2];
        end else begin : g_hi
            assign code = cfg_hi[2*(i-HALF) +: 2];
        end

        assign rise = lvl[i] & ~lvl_prev[i];
        assign fall = ~lvl[i] & lvl_prev[i];

        // Evaluate the selected condition for this pin.
        always_comb begin
            if (both_edge[i]) begin
                hit_b = rise | fall;
            end else begin
                unique case (gpio_cond_e'(code))
                    COND_LOW:  hit_b = ~lvl[i];
                    COND_HIGH: hit_b = lvl[i];
                    COND_RISE: hit_b = rise;
                    COND_FALL: hit_b = fall;
                    default:   hit_b = 1'b0;
                endcase
            end
        end

        assign hit[i] = hit_b;
    end

endmodule

// File: rtl/gpio_regfile.sv
// Module: bus register file of the pin controller.
// Holds the output latch, direction, both configuration words, the mask,
// the sticky status and the both-edges register. Status is write-one-to-clear,
// and a hit on the same edge wins over the clear. Reads are combinational.
// Assumes single-cycle accesses at word-aligned offsets.
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pad_lvl,
    input  logic [NPINS-1:0] hit,
    output logic [NPINS-1:0] dout_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] cfg_lo_q,
    output logic [NPINS-1:0] cfg_hi_q,
    output logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] stat_q,
    output logic [NPINS-1:0] both_q
);

    logic             wr_en;
    logic [NPINS-1:0] clr_bits;

    assign wr_en    = bus_sel & bus_wr;
    assign clr_bits = (wr_en && bus_addr == OFF_STAT[AW-1:0]) ? bus_wdata : '0;

    // Plain read/write registers, loaded on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
            both_q   <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFF_DOUT[AW-1:0])  dout_q   <= bus_wdata;
            if (bus_addr == OFF_DIR[AW-1:0])   dir_q    <= bus_wdata;
            if (bus_addr == OFF_CFGLO[AW-1:0]) cfg_lo_q <= bus_wdata;
            if (bus_addr == OFF_CFGHI[AW-1:0]) cfg_hi_q <= bus_wdata;
            if (bus_addr == OFF_MASK[AW-1:0])  mask_q   <= bus_wdata;
            if (bus_addr == OFF_BOTH[AW-1:0])  both_q   <= bus_wdata;
        end
    end

    // Sticky status: clear the written ones, then OR in this cycle's hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | hit;
        end
    end

    // Read multiplexer; unmapped offsets and idle cycles return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (bus_addr)
                OFF_DOUT[AW-1:0]:  bus_rdata = dout_q;
                OFF_DIR[AW-1:0]:   bus_rdata = dir_q;
                OFF_LEVEL[AW-1:0]: bus_rdata = pad_lvl;
                OFF_CFGLO[AW-1:0]: bus_rdata = cfg_lo_q;
                OFF_CFGHI[AW-1:0]: bus_rdata = cfg_hi_q;
                OFF_MASK[AW-1:0]:  bus_rdata = mask_q;
                OFF_STAT[AW-1:0]:  bus_rdata = stat_q;
                OFF_BOTH[AW-1:0]:  bus_rdata = both_q;
                default:           bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the pin controller with event detection.
// Chains synchroniser -> condition detector -> register file and folds the
// masked status into one interrupt per half of the pins. Assumes NPINS is even.
module gpio_irq_ctrl #(
    parameter int NPINS = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq_lo,
    output logic             irq_hi
);

    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] lvl, lvl_prev, hit;
    logic [NPINS-1:0] dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q, both_q;
    logic [NPINS-1:0] pending;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (pin_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    gpio_cond_detect #(.NPINS(NPINS)) u_detect (
        .lvl       (lvl),
        .lvl_prev  (lvl_prev),
        .cfg_lo    (cfg_lo_q),
        .cfg_hi    (cfg_hi_q),
        .both_edge (both_q),
        .hit       (hit)
    );

    gpio_regfile #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_lvl   (lvl),
        .hit       (hit),
        .dout_q    (dout_q),
        .dir_q     (dir_q),
        .cfg_lo_q  (cfg_lo_q),
        .cfg_hi_q  (cfg_hi_q),
        .mask_q    (mask_q),
        .stat_q    (stat_q),
        .both_q    (both_q)
    );

    // Pin drive straight from the latch and direction registers.
    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

    // Masked status folded per half into the two interrupt lines.
    assign pending = stat_q & mask_q;
    assign irq_lo  = |pending[HALF-1:0];
    assign irq_hi  = |pending[NPINS-1:HALF];

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Module: assertion checker for gpio_irq_ctrl, attached with bind below.
// Watches bus writes, the status and mask registers and the outputs.
module gpio_irq_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] stat_q,
    input logic [NPINS-1:0] mask_q,
    input logic             irq_lo,
    input logic             irq_hi
);

    localparam int HALF = NPINS / 2;

    logic stat_wr, dout_wr;
    assign stat_wr = bus_sel && bus_wr && (bus_addr == OFF_STAT[AW-1:0]);
    assign dout_wr = bus_sel && bus_wr && (bus_addr == OFF_DOUT[AW-1:0]);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && !irq_lo && !irq_hi && stat_q == '0));

    // R8
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R2
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_wr |=> $stable(pin_out));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (!irq_lo && !irq_hi));

    // R9
    irq_hi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (mask_q[NPINS-1:HALF] != '0));

    // R9
    irq_lo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (stat_q[HALF-1:0] != '0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .irq_lo   (irq_lo),
    .irq_hi   (irq_hi)
);

// File: tb/tb_gpio_irq_ctrl.sv
// Scoreboard bench: driver tasks queue expected/actual pairs, a monitor compares them.
module tb_gpio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] pin_in, pin_out, pin_oe;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    gpio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic push_chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        act_q.push_back(act);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        push_chk(bus_rdata, exp, tag);
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input logic [1:0] exp, input string tag);
        #1;
        push_chk({30'b0, irq_hi, irq_lo}, {30'b0, exp}, tag);
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop queued results and compare against expectations.
    always @(negedge clk) begin
        logic [31:0] a, e;
        string t;
        while (act_q.size() > 0) begin
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        settle(3);
        // R1 reset state
        push_chk(pin_out, 32'h0, "R1 pin_out in reset");
        push_chk(pin_oe, 32'h0, "R1 pin_oe in reset");
        chk_irq(2'b00, "R1 irq in reset");
        do_read(5'h18, 32'h0, "R1 status in reset");
        @(negedge clk);
        rst_n = 1'b1;
        settle(5);

        // R5 low-level code 0 on all pins (all low) floods status and re-asserts
        do_read(5'h18, 32'hFFFF_FFFF, "R5 low level sets status");
        do_write(5'h18, 32'hFFFF_FFFF);
        do_read(5'h18, 32'hFFFF_FFFF, "R8 set wins over clear on held level");
        chk_irq(2'b00, "R9 zero mask keeps irq low");

        // R2 output latch and direction
        do_write(5'h00, 32'hA5A5_0F0F);
        do_write(5'h04, 32'hFFFF_0000);
        push_chk(pin_out, 32'hA5A5_0F0F, "R2 pin_out follows latch");
        push_chk(pin_oe, 32'hFFFF_0000, "R2 pin_oe follows direction");
        do_read(5'h00, 32'hA5A5_0F0F, "R2 latch reads written value not pins");
        do_read(5'h04, 32'hFFFF_0000, "R10 direction offset readback");

        // R3 input level visibility and write immunity
        set_pins(32'h1234_5678);
        settle(4);
        do_read(5'h08, 32'h1234_5678, "R3 level register");
        do_write(5'h08, 32'hFFFF_FFFF);
        do_read(5'h08, 32'h1234_5678, "R3 write to level ignored");
        set_pins(32'h1234_5679);
        do_read(5'h08, 32'h1234_5678, "R3 old level after one edge");
        do_read(5'h08, 32'h1234_5679, "R3 new level after two edges");
        set_pins(32'h1234_5678);
        settle(4);

        // R4 / R5 high-level code 1
        do_write(5'h0C, 32'h5555_5555);
        do_write(5'h10, 32'h5555_5555);
        do_write(5'h18, 32'hFFFF_FFFF);
        do_read(5'h18, 32'h1234_5678, "R5 high level status after clear");
        do_read(5'h0C, 32'h5555_5555, "R10 lower config offset readback");

        // R6 rising code 2 with timing
        do_write(5'h0C, 32'hAAAA_AAAA);
        do_write(5'h10, 32'hAAAA_AAAA);
        do_write(5'h18, 32'hFFFF_FFFF);
        do_read(5'h18, 32'h0, "R6 no edges no status");
        set_pins(32'h1234_56F8);
        do_read(5'h18, 32'h0, "R6 not set after one edge");
        do_read(5'h18, 32'h0, "R6 not set after two edges");
        do_read(5'h18, 32'h0000_0080, "R6 set on third edge");
        set_pins(32'h1234_5678);
        settle(4);
        do_read(5'h18, 32'h0000_0080, "R6 falling edge ignored under rising code");
        do_write(5'h18, 32'h0000_0080);
        do_read(5'h18, 32'h0, "R8 one clears");

        // R4 falling code 3
        do_write(5'h0C, 32'hFFFF_FFFF);
        do_write(5'h10, 32'hFFFF_FFFF);
        set_pins(32'h1234_5670);
        settle(4);
        do_read(5'h18, 32'h0000_0008, "R4 falling code flags");
        set_pins(32'h1234_5678);
        settle(4);
        do_read(5'h18, 32'h0000_0008, "R6 rising ignored under falling code");
        do_write(5'h18, 32'h0000_0008);

        // R4 field positions in the upper word: pin17 rising, pin18 falling
        do_write(5'h0C, 32'hAAAA_AAAA);
        do_write(5'h10, 32'hFFFF_FFFB);
        set_pins(32'h1232_5678);
        settle(4);
        do_read(5'h18, 32'h0006_0000, "R4 upper field positions");
        do_write(5'h18, 32'h0006_0000);
        do_read(5'h18, 32'h0, "R8 clear upper bits");

        // R7 both-edges override on pin0 (code is low level)
        do_write(5'h0C, 32'hAAAA_AAA8);
        do_write(5'h1C, 32'h0000_0001);
        do_write(5'h18, 32'hFFFF_FFFF);
        do_read(5'h18, 32'h0, "R7 code ignored when both-edges set");
        do_read(5'h1C, 32'h0000_0001, "R10 both-edges offset readback");
        set_pins(32'h1232_5679);
        settle(4);
        do_read(5'h18, 32'h0000_0001, "R7 rising flagged");
        do_write(5'h18, 32'h0000_0001);
        set_pins(32'h1232_5678);
        settle(4);
        do_read(5'h18, 32'h0000_0001, "R7 falling flagged");

        // R9 mask and interrupt halves; R8 partial clear
        chk_irq(2'b00, "R9 mask zero");
        do_write(5'h14, 32'h0000_0001);
        chk_irq(2'b01, "R9 irq_lo from pin0");
        set_pins(32'h1230_5678);
        settle(4);
        set_pins(32'h1232_5678);
        settle(4);
        do_read(5'h18, 32'h0002_0001, "R9 status before unmask of pin17");
        chk_irq(2'b01, "R9 pin17 masked");
        do_write(5'h14, 32'h0002_0001);
        chk_irq(2'b11, "R9 both lines");
        do_read(5'h14, 32'h0002_0001, "R10 mask offset readback");
        do_write(5'h18, 32'h0000_0001);
        do_read(5'h18, 32'h0002_0000, "R8 zero bits keep status");
        chk_irq(2'b10, "R9 only irq_hi");
        do_write(5'h14, 32'h0);
        chk_irq(2'b00, "R9 mask cleared");

        settle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule